// File: doc/BRIEF.md
# UART Receive Queue Register Front-End

This block is the receive half of a memory-mapped serial port, placed between a bit deserializer and a 32-bit register port. The deserializer hands over one byte per cycle with optional parity and framing flags, or signals a line break. In queued mode the bytes go into a circular buffer whose depth is a parameter, and each bus read of the receive-data address removes the oldest byte. In direct mode a single holding register keeps only the most recent byte.

Software sees a control word, a data-ready bit, an occupancy word and a sticky error word that empties itself when read. Two one-cycle pulses, one for byte arrival and one for receive errors, drive the interrupt logic nearby. The receive queue can be flushed by a control bit that never reads back as set. All register reads return data one cycle after the read strobe.

Top module: `rxq_front`

## Requirements
- R1: After synchronous reset every readable word (control 0, data-ready status 1, error status 2, occupancy 3, receive data 4; word addresses) reads 0 and both pulse outputs are low.
- R2: Control word bit 0 selects queued mode and reads back as written; bit 1 (flush receive queue) and bit 2 (flush transmit queue) act once and always read back 0, as do all higher bits.
- R3: The occupancy word reports the stored byte count in bits [7:0] and a full flag in bit 8; when the queue holds DEPTH bytes it reads exactly 0x100.
- R4: In queued mode a read of the receive-data address returns the oldest byte in arrival order, removes it, and the data-ready bit (status bit 0) stays 1 only while bytes remain; storage wraps around without loss.
- R5: A receive-data read in queued mode with an empty queue returns 0 and produces an error pulse in the following cycle.
- R6: A byte that arrives while the queue is full and no read occurs in the same cycle is discarded, the stored contents stay unchanged, error bit 0 (overrun) is set and an error pulse follows.
- R7: When a byte arrives in the same cycle as a read of a full queue, the read returns the oldest byte, the new byte is stored, and no error pulse is produced.
- R8: In direct mode each received byte overwrites the holding register and sets data-ready; a receive-data read returns the held byte and clears data-ready.
- R9: The error word holds overrun in bit 0, parity in bit 1 and framing in bit 2 and break in bit 3; bits stay set until a read of the error word, which returns the value and leaves 0 behind.
- R10: A break event stores a 0x00 byte like a received byte and sets error bit 3.
- R11: Writing control bit 1 empties the receive queue in one cycle, so occupancy and data-ready read 0 afterwards.
- R12: Writes to the data-ready status, error, occupancy and receive-data addresses change nothing that can be read back.
- R13: Every cycle with an incoming byte is followed by exactly one cycle of the receive pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | Word address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops in queued mode at the data address) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| in_valid | input | 1 | Incoming byte present |
| in_byte | input | 8 | Incoming byte |
| in_parity_err | input | 1 | Parity flag for the incoming byte |
| in_frame_err | input | 1 | Framing flag for the incoming byte |
| in_break | input | 1 | Line break event |
| irq_rx | output | 1 | One-cycle pulse after a byte arrives |
| irq_err | output | 1 | One-cycle pulse after an overrun or an empty read |

## Verification
The hardest state to reach is a full queue receiving a byte in the very cycle a read removes one, since arrival and bus access come from unrelated sources and the outcome differs from plain overflow only by the timing of a single cycle. The bench fills the queue to exactly DEPTH, then raises the byte strobe and the read strobe on the same falling edge, and afterwards drains the whole queue to prove the new byte landed behind the oldest ones. Wrap-around is reached by repeated fill and drain rounds of changing length, so the pointers cross the end of storage at many different offsets.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int ADR_CTRL  = 0;
  localparam int ADR_READY = 1;
  localparam int ADR_ERR   = 2;
  localparam int ADR_OCC   = 3;
  localparam int ADR_DATA  = 4;

  localparam int ERR_W = 4;

  typedef struct packed {
    logic brk;
    logic frame;
    logic parity;
    logic overrun;
  } err_bits_t;
endpackage

// File: rtl/rxq_ring.sv
module rxq_ring #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it can map to distributed RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  assign dout  = mem[rd_ptr];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  assert_push_has_room_R6: assert property (@(posedge clk) disable iff (rst)
    push |-> (!full || pop));
  assert_pop_nonempty_R5: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  assert_flush_empties_R11: assert property (@(posedge clk) disable iff (rst)
    clr |=> empty);
endmodule

// File: rtl/rxq_errstat.sv
module rxq_errstat
  import rxq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  err_bits_t set,
  input  logic      rd_clr,
  output err_bits_t val
);
  always_ff @(posedge clk) begin
    if (rst)         val <= '0;
    else if (rd_clr) val <= set;
    else             val <= val | set;
  end

  assert_clear_on_read_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && set == '0) |=> (val == '0));
  assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (!rd_clr && val.overrun) |=> val.overrun);
endmodule

// File: rtl/rxq_front.sv
module rxq_front
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 3,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          in_valid,
  input  logic [7:0]    in_byte,
  input  logic          in_parity_err,
  input  logic          in_frame_err,
  input  logic          in_break,
  output logic          irq_rx,
  output logic          irq_err
);
  logic          q_mode;
  logic [7:0]    hold_byte;
  logic          hold_vld;
  logic [7:0]    head;
  logic [CW-1:0] occ;
  logic          q_full, q_empty;
  err_bits_t     err_set, err_val;

  wire hit_ctrl = (bus_addr == AW'(ADR_CTRL));
  wire hit_rdy  = (bus_addr == AW'(ADR_READY));
  wire hit_err  = (bus_addr == AW'(ADR_ERR));
  wire hit_occ  = (bus_addr == AW'(ADR_OCC));
  wire hit_data = (bus_addr == AW'(ADR_DATA));

  wire rd_data  = bus_rd && hit_data;
  wire flush    = bus_wr && hit_ctrl && bus_wdata[1];
  wire src_vld  = in_valid || in_break;
  wire [7:0] src_byte = in_break ? 8'h00 : in_byte;

  wire q_pop    = q_mode && rd_data && !q_empty;
  wire q_room   = !q_full || q_pop;
  wire q_push   = q_mode && src_vld && q_room && !flush;
  wire q_drop   = q_mode && src_vld && !q_room && !flush;
  wire pop_none = q_mode && rd_data && q_empty;
  wire ready    = q_mode ? !q_empty : hold_vld;

  logic unused_wbits;
  assign unused_wbits = ^{bus_wdata[31:2]};

  rxq_ring #(.DEPTH(DEPTH), .DW(8)) u_ring (
    .clk(clk), .rst(rst), .clr(flush), .push(q_push), .pop(q_pop),
    .din(src_byte), .dout(head), .count(occ), .full(q_full), .empty(q_empty)
  );

  always_comb begin
    err_set         = '0;
    err_set.overrun = q_drop;
    err_set.parity  = in_valid && !in_break && in_parity_err;
    err_set.frame   = in_valid && !in_break && in_frame_err;
    err_set.brk     = in_break;
  end

  rxq_errstat u_err (
    .clk(clk), .rst(rst), .set(err_set),
    .rd_clr(bus_rd && hit_err), .val(err_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      q_mode    <= 1'b0;
      hold_byte <= '0;
      hold_vld  <= 1'b0;
    end else begin
      if (bus_wr && hit_ctrl) q_mode <= bus_wdata[0];
      if (!q_mode && src_vld) begin
        hold_byte <= src_byte;
        hold_vld  <= 1'b1;
      end else if (!q_mode && rd_data) begin
        hold_vld  <= 1'b0;
      end
    end
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit_ctrl) rd_mux = {31'b0, q_mode};
    if (hit_rdy)  rd_mux = {31'b0, ready};
    if (hit_err)  rd_mux = {28'b0, err_val};
    if (hit_occ)  rd_mux = {23'b0, q_full, q_full ? 8'd0 : 8'(occ)};
    if (hit_data) rd_mux = q_mode ? (q_empty ? 32'd0 : {24'b0, head})
                                  : {24'b0, hold_byte};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_rx    <= 1'b0;
      irq_err   <= 1'b0;
    end else begin
      bus_rdata <= bus_rd ? rd_mux : 32'd0;
      irq_rx    <= in_valid;
      irq_err   <= q_drop || pop_none;
    end
  end

  assert_rx_pulse_R13: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> irq_rx);
  assert_empty_read_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && hit_data && q_mode && q_empty) |=> (irq_err && bus_rdata == 32'd0));
  assert_flag_clears_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && hit_ctrl) |=> (bus_rdata[2:1] == 2'b00));
endmodule

// File: tb/rxq_front_tb.sv
module rxq_front_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          in_valid = 1'b0;
  logic [7:0]    in_byte = '0;
  logic          in_parity_err = 1'b0, in_frame_err = 1'b0, in_break = 1'b0;
  logic          irq_rx, irq_err;

  int checks = 0;
  int errors = 0;
  logic last_rx, last_err;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rxq_front #(.DEPTH(DEPTH), .AW(AW)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .in_valid(in_valid),
    .in_byte(in_byte), .in_parity_err(in_parity_err), .in_frame_err(in_frame_err),
    .in_break(in_break), .irq_rx(irq_rx), .irq_err(irq_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata; last_err = irq_err;
    bus_rd = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input logic pe, input logic fe);
    @(negedge clk);
    in_byte = b; in_parity_err = pe; in_frame_err = fe; in_valid = 1'b1;
    @(negedge clk);
    last_rx = irq_rx; last_err = irq_err;
    in_valid = 1'b0; in_parity_err = 1'b0; in_frame_err = 1'b0;
  endtask

  task automatic brk();
    @(negedge clk);
    in_break = 1'b1;
    @(negedge clk);
    in_break = 1'b0;
  endtask

  function automatic logic [31:0] occ_exp(input int n);
    return (n == DEPTH) ? 32'h100 : 32'(n);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(a, d); chk("R1 reset read", d, 32'd0);
    end
    chk("R1 irq_rx low", {31'b0, irq_rx}, 32'd0);
    chk("R1 irq_err low", {31'b0, irq_err}, 32'd0);

    // R8 direct mode
    send(8'hA5, 1'b0, 1'b0);
    chk("R13 rx pulse", {31'b0, last_rx}, 32'd1);
    @(negedge clk);
    chk("R13 pulse one cycle", {31'b0, irq_rx}, 32'd0);
    rd(1, d); chk("R8 ready set", d, 32'd1);
    send(8'h3C, 1'b0, 1'b0);
    rd(4, d); chk("R8 overwrite data", d, 32'h3C);
    rd(1, d); chk("R8 ready cleared", d, 32'd0);

    // R2 control
    wr(0, 32'hFFFF_FFF9);
    rd(0, d); chk("R2 ctrl readback", d, 32'd1);
    wr(0, 32'h0000_0005);
    rd(0, d); chk("R2 flush bits self-clear", d, 32'd1);

    // R3 fill and occupancy
    for (int k = 1; k <= DEPTH; k++) begin
      send(8'(8'h10 + k), 1'b0, 1'b0);
      rd(3, d); chk("R3 occupancy", d, occ_exp(k));
    end
    // R6 overflow
    send(8'hEE, 1'b0, 1'b0);
    chk("R6 overflow err pulse", {31'b0, last_err}, 32'd1);
    rd(2, d); chk("R6 overrun bit", d, 32'd1);
    rd(2, d); chk("R9 cleared by read", d, 32'd0);
    rd(3, d); chk("R6 still full", d, 32'h100);

    // R4 drain in order
    for (int k = 1; k <= DEPTH; k++) begin
      rd(4, d); chk("R4 pop order", d, 32'(8'h10 + k));
      chk("R4 no err on pop", {31'b0, last_err}, 32'd0);
      rd(1, d); chk("R4 data ready", d, (k < DEPTH) ? 32'd1 : 32'd0);
    end

    // R5 empty pop
    rd(4, d); chk("R5 empty returns zero", d, 32'd0);
    chk("R5 empty err pulse", {31'b0, last_err}, 32'd1);

    // R9 parity and frame
    send(8'h01, 1'b1, 1'b0);
    send(8'h02, 1'b0, 1'b1);
    rd(2, d); chk("R9 parity+frame bits", d, 32'h6);
    rd(2, d); chk("R9 clear on read", d, 32'd0);
    rd(4, d); chk("R9 flagged byte stored", d, 32'h01);
    rd(4, d); chk("R9 flagged byte stored", d, 32'h02);

    // R10 break
    brk();
    rd(3, d); chk("R10 break occupancy", d, 32'd1);
    rd(2, d); chk("R10 break bit", d, 32'h8);
    rd(4, d); chk("R10 zero byte", d, 32'd0);
    chk("R10 no empty error", {31'b0, last_err}, 32'd0);

    // R12 ignored writes
    send(8'h77, 1'b0, 1'b0);
    send(8'h88, 1'b0, 1'b0);
    for (int a = 1; a < 5; a++) wr(a, 32'hFFFF_FFFF);
    rd(3, d); chk("R12 occupancy unchanged", d, 32'd2);
    rd(2, d); chk("R12 error word unchanged", d, 32'd0);
    rd(0, d); chk("R12 ctrl unchanged", d, 32'd1);
    rd(4, d); chk("R12 data intact", d, 32'h77);

    // R11 flush
    send(8'h99, 1'b0, 1'b0);
    wr(0, 32'h3);
    rd(3, d); chk("R11 flushed occupancy", d, 32'd0);
    rd(1, d); chk("R11 flushed ready", d, 32'd0);
    rd(0, d); chk("R11 mode kept", d, 32'd1);

    // R4 wrap-around sweep
    for (int r = 0; r < 12; r++) begin
      int n;
      n = ((r * 7) % DEPTH) + 1;
      for (int i = 0; i < n; i++) send(8'((r * 37 + i * 5) & 8'hFF), 1'b0, 1'b0);
      rd(3, d); chk("R3 sweep occupancy", d, occ_exp(n));
      for (int i = 0; i < n; i++) begin
        rd(4, d); chk("R4 sweep data", d, 32'((r * 37 + i * 5) & 8'hFF));
      end
    end

    // R7 push and pop in the same cycle on a full queue
    for (int k = 0; k < DEPTH; k++) send(8'(8'h40 + k), 1'b0, 1'b0);
    @(negedge clk);
    in_byte = 8'hC3; in_valid = 1'b1; bus_addr = AW'(4); bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    chk("R7 oldest returned", d, 32'h40);
    chk("R7 no error", {31'b0, irq_err}, 32'd0);
    in_valid = 1'b0; bus_rd = 1'b0;
    rd(3, d); chk("R7 still full", d, 32'h100);
    rd(2, d); chk("R7 no overrun", d, 32'd0);
    for (int k = 1; k <= DEPTH; k++) begin
      rd(4, d); chk("R7 drain", d, (k < DEPTH) ? 32'(8'h40 + k) : 32'hC3);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule